// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master that software drives through a small 32-bit memory-mapped slave port with a single-cycle acknowledge. Software loads up to 128 bits of outgoing data into four 32-bit data words. It sets a serial clock divider and an eight-bit slave-select mask, then writes one control word. That word fixes the transfer length, the bit order, the edges used for driving and sampling, the interrupt enable and automatic slave select, and it starts the transfer.

During a transfer the block drives the serial clock and the outgoing data line, and samples the incoming data line. Each received bit is written into the same data words in place of the bit it replaces. When the last serial clock period ends, the busy flag clears and an interrupt can be raised. Software then reads the received bits from the data word offsets.

Top module: `spim_core`

## Requirements
- R1: After reset `sclk`=0, `mosi`=0, `ss_n`=8'hFF, `irq`=0 and `bus_ack`=0. The control, divider, slave-select and all four data words read back as 0.
- R2: The offsets are taken from `bus_addr`, in bytes: data words 0..3 at 0x00/0x04/0x08/0x0C, control at 0x10, divider at 0x14, slave-select mask at 0x18. An idle write to any of them reads back the value written. Control bits [13:0] read back, with bit 8 showing the busy state.
- R3: Every access (`bus_cyc`&`bus_stb` high) is acknowledged with `bus_ack` high for exactly one cycle. Read data is valid in that cycle.
- R4: Writing control with bit 8 set while idle starts a transfer of N bits. N is control[6:0], and the value 0 means N=128. Exactly N rising `sclk` edges occur. Control bit 8 reads 1 while the transfer runs and reads 0 after the last falling edge.
- R5: With control bit 11 clear, `mosi` carries data bits N-1 down to 0. With bit 11 set, it carries bits 0 up to N-1. Bit positions count across the words, with bit 32*w+i being bit i of word w.
- R6: Control bit 10 set makes `mosi` change on falling `sclk` edges, with the first bit driven before the first rising edge. Control bit 10 clear makes it change on rising edges. Control bit 9 set makes `miso` be sampled on falling edges; clear, on rising edges.
- R7: The j-th sampled `miso` bit (j from 0) is stored at position N-1-j for MSB-first order or j for LSB-first order. Positions N and above keep their transmit values.
- R8: `sclk` idles low. Its period during a transfer is 2*(D+1) clock cycles, where D is the divider value.
- R9: `ss_n[i]` is low exactly when mask bit i is set and either control bit 13 is clear or a transfer is running.
- R10: When control bit 12 is set, `irq` rises as a transfer ends. It stays high until any access to a data word offset.
- R11: While a transfer runs, writes to the control or data offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle acknowledge |
| irq | output | 1 | Transfer-complete interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 8 | Slave selects, active low |

## Verification
The assertions check several rules on every cycle. The serial clock stays low while idle and holds its level between divider ticks. The acknowledge never lasts two cycles. The end of a transfer always clears busy on the next edge, and the interrupt only rises right after a completion. The control word and data words stay frozen during a transfer except for the sampling edges. Bit order, the drive and sample edge choices, the placement of received bits across word boundaries, the clock period, the slave-select timing and the interrupt clear on data access depend on whole transfers. Only the bench's scenarios, with a modelled slave, can show them.

// File: rtl/spim_pkg.sv
package spim_pkg;

   localparam int CTRL_W = 14;

   // control word layout, msb first (bit 13 down to bit 0)
   typedef struct packed {
      logic       auto_ss;    // 13
      logic       irq_en;     // 12
      logic       lsb_first;  // 11
      logic       tx_fall;    // 10
      logic       rx_fall;    // 9
      logic       go;         // 8
      logic       spare;      // 7
      logic [6:0] len;        // 6:0, 0 selects the full width
   } spim_ctrl_t;

   // register slots, selected by bus_addr[4:2]
   localparam logic [2:0] SLOT_CTRL = 3'd4;
   localparam logic [2:0] SLOT_DIV  = 3'd5;
   localparam logic [2:0] SLOT_SS   = 3'd6;

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             busy_i,
   input  logic             start_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;
   logic             tick;

   if (DIV_W < 1) begin : g_bad_div
      $error("spim_clkgen: DIV_W must be at least 1");
   end

   assign tick   = busy_i && !start_i && (cnt_q == '0);
   assign rise_o = tick && !sclk_q;
   assign fall_o = tick && sclk_q;
   assign sclk_o = sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!busy_i || start_i) begin
         cnt_q  <= div_i;
         sclk_q <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q  <= div_i;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q - DIV_W'(1);
      end
   end

   // R8: serial clock is low whenever no transfer runs
   p_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
      !busy_i |=> !sclk_o);

   // R8: level held while the divider is still counting
   p_half_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (busy_i && !start_i && cnt_q != '0) |=> $stable(sclk_o));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter  int DATA_W    = 32,
   parameter  int NUM_WORDS = 4,
   localparam int TOTAL     = DATA_W * NUM_WORDS,
   localparam int POS_W     = $clog2(TOTAL),
   localparam int CNT_W     = POS_W + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_WORDS-1:0] wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 start_i,
   input  logic                 busy_i,
   input  logic                 rise_i,
   input  logic                 fall_i,
   input  logic [POS_W-1:0]     len_i,
   input  logic                 lsb_first_i,
   input  logic                 tx_fall_i,
   input  logic                 rx_fall_i,
   input  logic                 miso_i,
   output logic                 mosi_o,
   output logic                 done_o,
   output logic [TOTAL-1:0]     words_o
);

   if (TOTAL != (1 << POS_W)) begin : g_bad_total
      $error("spim_shifter: total width must be a power of two");
   end
   if (POS_W > 7) begin : g_bad_len
      $error("spim_shifter: length field holds at most 128 bits");
   end

   logic [TOTAL-1:0] data_q;
   logic [CNT_W-1:0] tx_cnt_q, rx_cnt_q, per_cnt_q;
   logic [CNT_W-1:0] nbits;
   logic [POS_W-1:0] tx_pos, rx_pos, first_pos;
   logic             mosi_q;
   logic             tx_ev, rx_ev;

   function automatic logic [POS_W-1:0] map_pos(input logic lsb,
                                                input logic [CNT_W-1:0] n,
                                                input logic [CNT_W-1:0] idx);
      logic [CNT_W-1:0] down;
      down = n - CNT_W'(1) - idx;
      return lsb ? idx[POS_W-1:0] : down[POS_W-1:0];
   endfunction

   assign nbits     = (len_i == '0) ? CNT_W'(TOTAL) : {1'b0, len_i};
   assign tx_pos    = map_pos(lsb_first_i, nbits, tx_cnt_q);
   assign rx_pos    = map_pos(lsb_first_i, nbits, rx_cnt_q);
   assign first_pos = map_pos(lsb_first_i, nbits, '0);
   assign tx_ev     = tx_fall_i ? fall_i : rise_i;
   assign rx_ev     = rx_fall_i ? fall_i : rise_i;
   assign done_o    = fall_i && (per_cnt_q == nbits - CNT_W'(1));
   assign mosi_o    = mosi_q;
   assign words_o   = data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q    <= '0;
         tx_cnt_q  <= '0;
         rx_cnt_q  <= '0;
         per_cnt_q <= '0;
         mosi_q    <= 1'b0;
      end else if (start_i) begin
         rx_cnt_q  <= '0;
         per_cnt_q <= '0;
         if (tx_fall_i) begin
            mosi_q   <= data_q[first_pos];
            tx_cnt_q <= CNT_W'(1);
         end else begin
            tx_cnt_q <= '0;
         end
      end else begin
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (wr_en[w]) data_q[w*DATA_W +: DATA_W] <= wr_data;
         end
         if (rx_ev) begin
            data_q[rx_pos] <= miso_i;
            rx_cnt_q       <= rx_cnt_q + CNT_W'(1);
         end
         if (tx_ev && tx_cnt_q < nbits) begin
            mosi_q   <= data_q[tx_pos];
            tx_cnt_q <= tx_cnt_q + CNT_W'(1);
         end
         if (fall_i) per_cnt_q <= per_cnt_q + CNT_W'(1);
      end
   end

   // R4: never more samples than the programmed length
   p_rx_bound_r4: assert property (@(posedge clk) disable iff (rst)
      (busy_i && !start_i) |-> (rx_cnt_q <= nbits));

   // R11: during a transfer only sampling edges alter the data words
   p_data_frozen_r11: assert property (@(posedge clk) disable iff (rst)
      (busy_i && !rx_ev) |=> $stable(data_q));

endmodule

// File: rtl/spim_core.sv
module spim_core
   import spim_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_WORDS = 4,
   parameter int SS_W      = 8,
   parameter int DIV_W     = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_cyc,
   input  logic              bus_stb,
   input  logic              bus_we,
   input  logic [4:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ack,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [SS_W-1:0]   ss_n
);

   localparam int TOTAL = DATA_W * NUM_WORDS;
   localparam int POS_W = $clog2(TOTAL);

   if (DATA_W != 32) begin : g_bad_data
      $error("spim_core: bus width is fixed at 32 bits");
   end
   if (NUM_WORDS < 1 || NUM_WORDS > 4) begin : g_bad_words
      $error("spim_core: one to four data words fit the map");
   end
   if (SS_W < 1 || SS_W > DATA_W) begin : g_bad_ss
      $error("spim_core: slave-select width out of range");
   end
   if (DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_div
      $error("spim_core: divider width out of range");
   end

   logic              ack_q, busy_q, start_q, irq_q;
   logic [DATA_W-1:0] rdata_q, rd_mux;
   spim_ctrl_t        ctrl_q, ctrl_wr, ctrl_new, ctrl_rd;
   logic [DIV_W-1:0]  div_q;
   logic [SS_W-1:0]   ss_q;
   logic              acc, wr, data_hit;
   logic [2:0]        slot;
   logic [NUM_WORDS-1:0] wr_en;
   logic              rise_w, fall_w, done_w;
   logic [TOTAL-1:0]  words;
   logic              unused_addr_bits;

   assign acc      = bus_cyc && bus_stb && !ack_q;
   assign wr       = acc && bus_we;
   assign slot     = bus_addr[4:2];
   assign data_hit = (int'(slot) < NUM_WORDS);
   assign unused_addr_bits = ^bus_addr[1:0];

   assign ctrl_wr = spim_ctrl_t'(bus_wdata[CTRL_W-1:0]);
   always_comb begin
      ctrl_new    = ctrl_wr;
      ctrl_new.go = 1'b0;
      ctrl_rd     = ctrl_q;
      ctrl_rd.go  = busy_q;
   end

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wen
      assign wr_en[w] = wr && !busy_q && (slot == 3'(w));
   end

   always_comb begin
      rd_mux = '0;
      case (slot)
         SLOT_CTRL: rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_rd};
         SLOT_DIV:  rd_mux = DATA_W'(div_q);
         SLOT_SS:   rd_mux = DATA_W'(ss_q);
         default: begin
            for (int w = 0; w < NUM_WORDS; w++) begin
               if (slot == 3'(w)) rd_mux = words[w*DATA_W +: DATA_W];
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q   <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
         rdata_q <= '0;
         ctrl_q  <= '0;
         div_q   <= '0;
         ss_q    <= '0;
      end else begin
         ack_q   <= acc;
         start_q <= 1'b0;
         if (acc && !bus_we) rdata_q <= rd_mux;
         if (wr && slot == SLOT_CTRL && !busy_q) begin
            ctrl_q <= ctrl_new;
            if (ctrl_wr.go) begin
               busy_q  <= 1'b1;
               start_q <= 1'b1;
            end
         end
         if (wr && slot == SLOT_DIV) div_q <= bus_wdata[DIV_W-1:0];
         if (wr && slot == SLOT_SS)  ss_q  <= bus_wdata[SS_W-1:0];
         if (acc && data_hit) irq_q <= 1'b0;
         if (done_w) begin
            busy_q <= 1'b0;
            if (ctrl_q.irq_en) irq_q <= 1'b1;
         end
      end
   end

   spim_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk     (clk),
      .rst     (rst),
      .busy_i  (busy_q),
      .start_i (start_q),
      .div_i   (div_q),
      .sclk_o  (sclk),
      .rise_o  (rise_w),
      .fall_o  (fall_w)
   );

   spim_shifter #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_shifter (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_en),
      .wr_data     (bus_wdata),
      .start_i     (start_q),
      .busy_i      (busy_q),
      .rise_i      (rise_w),
      .fall_i      (fall_w),
      .len_i       (ctrl_q.len[POS_W-1:0]),
      .lsb_first_i (ctrl_q.lsb_first),
      .tx_fall_i   (ctrl_q.tx_fall),
      .rx_fall_i   (ctrl_q.rx_fall),
      .miso_i      (miso),
      .mosi_o      (mosi),
      .done_o      (done_w),
      .words_o     (words)
   );

   assign bus_ack   = ack_q;
   assign bus_rdata = rdata_q;
   assign irq       = irq_q;
   assign ss_n      = ~(ss_q & {SS_W{!ctrl_q.auto_ss || busy_q}});

   // R3: acknowledge lasts a single cycle
   p_ack_single_r3: assert property (@(posedge clk) disable iff (rst)
      bus_ack |=> !bus_ack);

   // R4: the last falling edge ends the busy state
   p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
      done_w |=> !busy_q);

   // R10: interrupt only rises right after a completion
   p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_q) |-> $past(done_w));

   // R11: control word locked while a transfer runs
   p_ctrl_locked_r11: assert property (@(posedge clk) disable iff (rst)
      busy_q |=> $stable(ctrl_q));

endmodule

// File: tb/test_spim_core.sv
module test_spim_core;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ack, irq, sclk, mosi;
   logic        miso = 1'b0;
   logic [7:0]  ss_n;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // scoreboard and slave model state
   bit           exp_q[$];
   bit           mon_on = 0;
   bit           cur_txf = 0, cur_rxf = 0;
   logic [127:0] slv_bits = '0;
   int           rxc = 0;
   int           rise_cnt = 0;
   bit           have_prev = 0;
   realtime      prev_t = 0.0, rise_per = 0.0;
   bit           last_ack = 0;

   always #2.5 clk = ~clk;

   spim_core i_spim_core (
      .clk(clk), .rst(rst), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: pops the expected serial bit at mid-bit
   task automatic take_bit(input logic b);
      bit e;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R4", "extra mosi bit", 128'(b), 128'h0);
      end else begin
         e = exp_q.pop_front();
         chk(b === e, "R5,R6", "mosi bit", 128'(b), 128'(e));
      end
   endtask

   always @(posedge sclk) if (mon_on && cur_txf)  take_bit(mosi);
   always @(negedge sclk) if (mon_on && !cur_txf) take_bit(mosi);

   // slave: present the next bit after each master sampling edge
   always @(posedge sclk) if (mon_on && !cur_rxf) begin
      rxc++;
      miso = (rxc < 128) ? slv_bits[rxc] : 1'b0;
   end
   always @(negedge sclk) if (mon_on && cur_rxf) begin
      rxc++;
      miso = (rxc < 128) ? slv_bits[rxc] : 1'b0;
   end

   always @(posedge sclk) if (mon_on) begin
      rise_cnt++;
      if (have_prev) rise_per = $realtime - prev_t;
      prev_t    = $realtime;
      have_prev = 1;
   end

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      last_ack = bus_ack;
      bus_cyc = 0; bus_stb = 0; bus_we = 0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_addr = a;
      @(negedge clk);
      last_ack = bus_ack;
      d = bus_rdata;
      bus_cyc = 0; bus_stb = 0;
   endtask

   // driver: programs one transfer, pushes its expected bits, checks the result
   task automatic launch(input int len, input bit lsb, input bit txf, input bit rxf,
                         input bit ie, input bit aut, input int div,
                         input logic [127:0] txd, input logic [127:0] slv,
                         input bit poke);
      int n;
      logic [127:0] exp_data;
      logic [31:0]  ctrl, r;
      bit first_busy;
      int polls;
      n = (len == 0) ? 128 : len;
      bus_write(5'h14, 32'(div));
      bus_write(5'h18, 32'h05);
      for (int w = 0; w < 4; w++) bus_write(5'(w*4), txd[w*32 +: 32]);
      exp_data = txd;
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(lsb ? txd[k] : txd[n-1-k]);
         exp_data[lsb ? k : n-1-k] = slv[k];
      end
      cur_txf = txf; cur_rxf = rxf; slv_bits = slv; rxc = 0; miso = slv[0];
      rise_cnt = 0; have_prev = 0; rise_per = 0.0;
      mon_on = 1;
      ctrl = {18'h0, aut, ie, lsb, txf, rxf, 1'b1, 1'b0, 7'(len)};
      bus_write(5'h10, ctrl);
      chk(ss_n === 8'hFA, "R9", "ss_n while running", 128'(ss_n), 128'hFA);
      if (poke) begin
         bus_write(5'h00, 32'hDEAD_BEEF);
         bus_write(5'h10, 32'h0000_0105);
      end
      polls = 0;
      bus_read(5'h10, r);
      first_busy = r[8];
      while (r[8] && polls < 2000) begin
         bus_read(5'h10, r);
         polls++;
      end
      mon_on = 0;
      chk(first_busy == 1'b1, "R4", "busy bit during transfer", 128'(first_busy), 128'h1);
      chk(r[8] == 1'b0, "R4", "busy bit after transfer", 128'(r[8]), 128'h0);
      chk(exp_q.size() == 0, "R4", "bits left unsent", 128'(exp_q.size()), 128'h0);
      chk(rise_cnt == n, "R4", "sclk rising edges", 128'(rise_cnt), 128'(n));
      exp_q.delete();
      if (n >= 2)
         chk($rtoi(rise_per * 10.0) == (div + 1) * 100, "R8", "sclk period x0.1ns",
             128'($rtoi(rise_per * 10.0)), 128'((div + 1) * 100));
      chk(sclk === 1'b0, "R8", "sclk idle level", 128'(sclk), 128'h0);
      chk(ss_n === (aut ? 8'hFF : 8'hFA), "R9", "ss_n after transfer",
          128'(ss_n), 128'(aut ? 8'hFF : 8'hFA));
      chk(irq === ie, "R10", "irq after transfer", 128'(irq), 128'(ie));
      chk(r[13:0] == (ctrl[13:0] & 14'h3EFF), "R11", "control readback",
          128'(r[13:0]), 128'(ctrl[13:0] & 14'h3EFF));
      for (int w = 0; w < 4; w++) begin
         bus_read(5'(w*4), r);
         chk(r == exp_data[w*32 +: 32], "R7", $sformatf("received word %0d", w),
             128'(r), 128'(exp_data[w*32 +: 32]));
         if (w == 0) begin
            @(negedge clk);
            chk(irq === 1'b0, "R10", "irq cleared by data access", 128'(irq), 128'h0);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (5) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1: reset state at the ports and in every register
      chk(sclk === 1'b0, "R1", "sclk", 128'(sclk), 128'h0);
      chk(mosi === 1'b0, "R1", "mosi", 128'(mosi), 128'h0);
      chk(ss_n === 8'hFF, "R1", "ss_n", 128'(ss_n), 128'hFF);
      chk(irq === 1'b0, "R1", "irq", 128'(irq), 128'h0);
      chk(bus_ack === 1'b0, "R1", "bus_ack", 128'(bus_ack), 128'h0);
      for (int a = 0; a < 7; a++) begin
         bus_read(5'(a*4), r);
         chk(r == 32'h0, "R1", $sformatf("register at 0x%0h", a*4), 128'(r), 128'h0);
      end

      // R3: one-cycle acknowledge on read and write
      bus_read(5'h10, r);
      chk(last_ack == 1'b1, "R3", "ack on read", 128'(last_ack), 128'h1);
      @(negedge clk);
      chk(bus_ack === 1'b0, "R3", "ack dropped after read", 128'(bus_ack), 128'h0);
      bus_write(5'h14, 32'h1234);
      chk(last_ack == 1'b1, "R3", "ack on write", 128'(last_ack), 128'h1);
      @(negedge clk);
      chk(bus_ack === 1'b0, "R3", "ack dropped after write", 128'(bus_ack), 128'h0);

      // R2: idle readback of every offset
      bus_write(5'h18, 32'hA5);
      bus_write(5'h10, 32'h3A45);
      bus_write(5'h00, 32'h0123_4567);
      bus_write(5'h04, 32'h89AB_CDEF);
      bus_write(5'h08, 32'h5555_AAAA);
      bus_write(5'h0C, 32'hF0F0_0F0F);
      bus_read(5'h14, r); chk(r == 32'h1234, "R2", "divider", 128'(r), 128'h1234);
      bus_read(5'h18, r); chk(r == 32'hA5, "R2", "slave-select mask", 128'(r), 128'hA5);
      bus_read(5'h10, r); chk(r == 32'h3A45, "R2", "control", 128'(r), 128'h3A45);
      bus_read(5'h00, r); chk(r == 32'h0123_4567, "R2", "word 0", 128'(r), 128'h0123_4567);
      bus_read(5'h04, r); chk(r == 32'h89AB_CDEF, "R2", "word 1", 128'(r), 128'h89AB_CDEF);
      bus_read(5'h08, r); chk(r == 32'h5555_AAAA, "R2", "word 2", 128'(r), 128'h5555_AAAA);
      bus_read(5'h0C, r); chk(r == 32'hF0F0_0F0F, "R2", "word 3", 128'(r), 128'hF0F0_0F0F);

      // 8 bits, msb first, drive rising, sample falling, fastest clock
      launch(8, 0, 0, 1, 0, 0, 0, 128'h0000_0000_0000_0000_0000_0000_0000_005A,
             128'hC3D2_E1F0_0F1E_2D3C_4B5A_6978_8796_A5B4, 0);
      // 16 bits, lsb first, drive falling, sample rising, divider 2
      launch(16, 1, 1, 0, 0, 0, 2, 128'h1111_2222_3333_4444_5555_6666_7777_5AA5,
             128'h0000_0000_0000_0000_0000_0000_0000_7E5A, 0);
      // full 128 bits (length 0), msb first, both on rising edges
      launch(0, 0, 0, 0, 0, 0, 0, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF,
             128'h7F3B_5D19_A55A_5AA5_0124_8421_FEDC_BA98, 0);
      // single bit with interrupt and automatic select
      launch(1, 1, 0, 1, 1, 1, 0, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE,
             128'h0000_0000_0000_0000_0000_0000_0000_0001, 0);
      // 37 bits across a word boundary, both on falling edges, writes while busy
      launch(37, 0, 1, 1, 1, 0, 3, 128'hCAFE_F00D_1357_9BDF_0000_0019_8765_4321,
             128'h0000_0000_0000_0000_0000_0013_5A5A_F00F, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule